// File: doc/BRIEF.md
# Keyed-write watchdog and interval timer

This block is a timer peripheral with an 8-bit up-counter and an 8-bit control/status register, both reached over a small register bus. The control register starts and stops the count and picks the count rate from a prescaler of the peripheral clock. It also picks between watchdog and interval operation and sets the kind of reset to request. Two of its bits are overflow flags. Software must keep reloading the counter before it wraps. If it does not, a watchdog-mode overflow sends a one-cycle power-on or manual reset request to the chip's reset logic. In interval mode the same wrap sets a flag that holds an interrupt request high until software clears it.

A runaway program must not be able to disturb the timer by accident, so writes are guarded. A write lands only as a 16-bit access whose upper byte holds the key for that register, with the new value in the lower byte. The key is 0xA5 for the control register and 0x5A for the counter. Reads are single bytes. Two reset inputs act differently. The external power-on reset clears everything. The internal reset, which follows a watchdog-caused reset, clears only the counter and prescaler, so software can see afterwards why the chip restarted.

Top module: `wdog_keyed_timer`

## Requirements
- R1: After `rst_n` low, the control register reads 0x00, the counter reads 0x00, and `por_req`, `mrst_req` and `irq` are 0.
- R2: A control-register write (`bus_addr`=0) lands only when `bus_word`=1 and `bus_wdata[15:8]`=0xA5. It loads enable (bit 7), mode (bit 6, 1 = watchdog, 0 = interval), reset select (bit 5) and clock select (bits 2:0) from `bus_wdata[7:0]` on the write edge. A byte write or a word write with any other key leaves the register unchanged.
- R3: A counter write (`bus_addr`=1) lands only when `bus_word`=1 and `bus_wdata[15:8]`=0x5A, loading `bus_wdata[7:0]`. Byte writes and other keys leave the counter unchanged.
- R4: While enable is 0 the counter holds its value.
- R5: When enable is set on a write edge, the counter increments once every N clock cycles, with N = 1, 4, 16, 32, 64, 256, 1024 or 4096 for clock select codes 0 to 7. The first increment comes N cycles after the enabling edge.
- R6: In watchdog mode with reset select 0, a wrap from 0xFF to 0x00 sets the watchdog flag (bit 4) and drives `por_req` high for exactly one cycle, starting on the wrap edge.
- R7: In watchdog mode with reset select 1, a wrap drives `mrst_req` instead for one cycle. The two requests are never high together.
- R8: In interval mode a wrap sets the interval flag (bit 3) and raises no reset request, whatever reset select holds. `irq` is high exactly while bit 3 is 1.
- R9: A keyed control write with 0 in a flag bit clears that flag. A 1 in a flag bit leaves that flag as it was.
- R10: When a wrap and a keyed clear of the same flag fall on the same edge, the flag ends up set.
- R11: Holding `core_rst_n` low for a cycle clears the counter and the prescaler but leaves the control register, including its flags, unchanged.
- R12: `bus_rdata` shows the control register when `bus_addr`=0 and the counter when `bus_addr`=1, without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | External power-on reset, synchronous, active low; clears all state |
| core_rst_n | input | 1 | Internal reset, synchronous, active low; clears counter and prescaler only |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 1 | 0 = control/status register, 1 = counter |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 8 | Read data of the addressed register |
| por_req | output | 1 | One-cycle power-on reset request |
| mrst_req | output | 1 | One-cycle manual reset request |
| irq | output | 1 | Interval overflow interrupt request |

## Verification
The hardest case to reach is a keyed flag clear that lands on the very edge where the counter wraps. The stimulus gets there with a counter preload of 0xFE and the fastest prescaler tap. Two cycles after enabling, the clearing write is timed to meet the wrap exactly, in both modes. The internal-reset case also needs set-up. Watchdog overflow must first leave a flag and reset-select settings in the register, so that keeping them can be told apart from clearing them. The rest is covered by full sweeps of every control and counter value, each followed by wrong-key and byte-size writes, and by a timing check of every prescaler tap.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Shared layout of the control/status register, the write keys and the
// prescaler tap table. Software decodes these bit positions directly.
package wdt_pkg;

    localparam int REG_W   = 8;
    localparam int N_TAPS  = 8;
    localparam int CKS_W   = $clog2(N_TAPS);

    localparam logic [REG_W-1:0] CTRL_KEY = 8'hA5;
    localparam logic [REG_W-1:0] CNT_KEY  = 8'h5A;

    // Control/status register, bit 7 first.
    typedef struct packed {
        logic             en;     // 7: count enable
        logic             wdog;   // 6: 1 = watchdog, 0 = interval
        logic             rsel;   // 5: 0 = power-on request, 1 = manual request
        logic             wflag;  // 4: watchdog overflow flag
        logic             iflag;  // 3: interval overflow flag
        logic [CKS_W-1:0] cks;    // 2:0: prescaler tap
    } ctrl_t;

    // log2 of the division ratio for each clock select code
    function automatic int tap_shift(input int code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 8;
            6:       return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Module wdt_prescaler
// Free-running divider of the peripheral clock that yields a one-cycle
// count tick at the selected tap. Assumes: the divider is held at zero while
// counting is disabled, so the first tick after enabling comes a full
// period later; PRE_W is at least the largest tap shift.
module wdt_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     core_rst_n,
    input  logic                     run,
    input  logic [wdt_pkg::CKS_W-1:0] cks,
    output logic                     tick
);
    import wdt_pkg::*;

    logic [PRE_W-1:0]  pre_q;
    logic [N_TAPS-1:0] tap_hit;

    // Divider: advance while running, otherwise park at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst_n || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One terminal-count detector per tap.
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        localparam int               SH   = tap_shift(t);
        localparam logic [PRE_W-1:0] MASK = {PRE_W{1'b1}} >> (PRE_W - SH);
        assign tap_hit[t] = ((pre_q & MASK) == MASK);
    end

    // Tap select and gate.
    always_comb begin
        tick = run & tap_hit[cks];
    end

endmodule

// File: rtl/wdt_counter.sv
// Module wdt_counter
// Up-counter that software can load. It steps on each prescaler tick and
// flags the wrap from all ones to zero. Assumes: a load wins over a tick on
// the same edge and suppresses that wrap; internal reset blocks the wrap.
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: reset, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Wrap event for the flag and request logic.
    always_comb begin
        wrap = tick & ~load & core_rst_n & (cnt_q == {CNT_W{1'b1}});
        cnt  = cnt_q;
    end

endmodule

// File: rtl/wdt_ctrl_reg.sv
// Module wdt_ctrl_reg
// Control/status register. A keyed write loads the control fields. Flags are
// set by hardware events and cleared only by writing 0, and a set event
// beats a clear on the same edge. Assumes: wr_ok already holds the key and
// size check; cleared only by the power-on reset.
module wdt_ctrl_reg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_ok,
    input  logic [wdt_pkg::REG_W-1:0] wdata,
    input  logic                      wflag_set,
    input  logic                      iflag_set,
    output wdt_pkg::ctrl_t            ctrl
);
    import wdt_pkg::*;

    ctrl_t ctrl_q;
    ctrl_t wr_v;
    logic  wflag_clr;
    logic  iflag_clr;

    // Decode the write value and the clear strobes.
    always_comb begin
        wr_v      = ctrl_t'(wdata);
        wflag_clr = wr_ok & ~wr_v.wflag;
        iflag_clr = wr_ok & ~wr_v.iflag;
    end

    // Register update: control fields on write, flags set-dominant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ok) begin
                ctrl_q.en   <= wr_v.en;
                ctrl_q.wdog <= wr_v.wdog;
                ctrl_q.rsel <= wr_v.rsel;
                ctrl_q.cks  <= wr_v.cks;
            end
            ctrl_q.wflag <= wflag_set | (ctrl_q.wflag & ~wflag_clr);
            ctrl_q.iflag <= iflag_set | (ctrl_q.iflag & ~iflag_clr);
        end
    end

    assign ctrl = ctrl_q;

    // R10
    wflag_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wflag_set |=> ctrl_q.wflag);

    // R10
    iflag_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iflag_set |=> ctrl_q.iflag);

endmodule

// File: rtl/wdog_keyed_timer.sv
// Module wdog_keyed_timer
// Top of the keyed-write watchdog / interval timer. Decodes keyed bus writes,
// joins prescaler, counter and control register, and turns wraps into reset
// requests or an interrupt. Assumes: single-cycle bus accesses with reads
// served from the current address; the reset requests go to an external
// reset generator.
module wdog_keyed_timer #(
    parameter int PRE_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        core_rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        por_req,
    output logic        mrst_req,
    output logic        irq
);
    import wdt_pkg::*;

    ctrl_t            ctrl;
    logic [REG_W-1:0] cnt;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             ctrl_try;
    logic             tick;
    logic             wrap;
    logic             por_q;
    logic             mrst_q;

    // Keyed write decode: word size plus per-register key.
    always_comb begin
        ctrl_try = bus_sel & bus_wr & ~bus_addr;
        ctrl_wr  = ctrl_try & bus_word & (bus_wdata[15:8] == CTRL_KEY);
        cnt_wr   = bus_sel & bus_wr & bus_addr & bus_word
                 & (bus_wdata[15:8] == CNT_KEY);
    end

    wdt_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .run        (ctrl.en),
        .cks        (ctrl.cks),
        .tick       (tick)
    );

    wdt_counter #(.CNT_W(REG_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .load       (cnt_wr),
        .load_val   (bus_wdata[REG_W-1:0]),
        .tick       (tick),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    wdt_ctrl_reg i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (ctrl_wr),
        .wdata      (bus_wdata[REG_W-1:0]),
        .wflag_set  (wrap & ctrl.wdog),
        .iflag_set  (wrap & ~ctrl.wdog),
        .ctrl       (ctrl)
    );

    // Reset request pulses, one cycle per watchdog wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q  <= 1'b0;
            mrst_q <= 1'b0;
        end else begin
            por_q  <= wrap & ctrl.wdog & ~ctrl.rsel;
            mrst_q <= wrap & ctrl.wdog &  ctrl.rsel;
        end
    end

    // Outputs: requests, interrupt and read mux.
    always_comb begin
        por_req   = por_q;
        mrst_req  = mrst_q;
        irq       = ctrl.iflag;
        bus_rdata = bus_addr ? cnt : REG_W'(ctrl);
    end

    // R2
    ctrl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_try && !(bus_word && bus_wdata[15:8] == CTRL_KEY))
        |=> ($stable(ctrl.en) && $stable(ctrl.wdog) && $stable(ctrl.rsel)
             && $stable(ctrl.cks)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !cnt_wr && core_rst_n) |=> $stable(cnt));

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req || mrst_req) |=> (!por_req && !mrst_req));

    // R7
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({por_req, mrst_req}));

    // R8
    irq_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!por_req && !mrst_req));

    // R11
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_rst_n && !ctrl_wr) |=> $stable(ctrl));

endmodule

// File: tb/test_wdog_keyed_timer.sv
`timescale 1ns/1ps
// Bench for wdog_keyed_timer: full sweeps of register values with bad-key
// and byte writes, per-tap timing, and wrap corner cases.
module test_wdog_keyed_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_rst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        por_req;
    logic        mrst_req;
    logic        irq;

    int vectors = 0;
    int fails   = 0;

    wdog_keyed_timer i_wdog_keyed_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_word   (bus_word),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .por_req    (por_req),
        .mrst_req   (mrst_req),
        .irq        (irq)
    );

    always #2.5 clk = ~clk;

    // Compare one value and log a miscompare.
    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Read a register through the bus and compare.
    task automatic check_reg(input string tag, input logic addr, input logic [7:0] exp);
        bus_addr = addr;
        #0.5;
        check(tag, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    // One bus write; called and returns just after a falling edge.
    task automatic bus_write(input logic addr, input logic word, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = addr; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int taps [8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_reg("R1 ctrl", 1'b0, 8'h00);
        check_reg("R1 cnt", 1'b1, 8'h00);
        check("R1 requests", {13'd0, por_req, mrst_req, irq}, 16'h0000);

        // R2 sweep of control values with rejected writes
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            logic [7:0] k;
            vb = 8'(v);
            k  = (vb == 8'hA5) ? 8'h00 : vb;
            bus_write(1'b1, 1'b1, {8'h5A, 8'h00});
            bus_write(1'b0, 1'b1, {8'hA5, vb});
            check_reg("R2 R12 keyed ctrl", 1'b0, vb & 8'hE7);
            bus_write(1'b0, 1'b1, {k, ~vb});
            check_reg("R2 bad key", 1'b0, vb & 8'hE7);
            bus_write(1'b0, 1'b0, {8'hA5, ~vb});
            check_reg("R2 byte write", 1'b0, vb & 8'hE7);
        end
        bus_write(1'b0, 1'b1, 16'hA500);

        // R3 sweep of counter values with rejected writes
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            cb = 8'(c);
            bus_write(1'b1, 1'b1, {8'h5A, cb});
            check_reg("R3 R12 keyed cnt", 1'b1, cb);
            bus_write(1'b1, 1'b1, {8'hA5, ~cb});
            check_reg("R3 bad key", 1'b1, cb);
            bus_write(1'b1, 1'b0, {8'h5A, ~cb});
            check_reg("R3 byte write", 1'b1, cb);
        end

        // R4 hold while disabled, and after stopping
        bus_write(1'b1, 1'b1, 16'h5A40);
        step(50);
        check_reg("R4 idle hold", 1'b1, 8'h40);
        bus_write(1'b0, 1'b1, 16'hA581);
        step(10);
        check_reg("R5 div4 run", 1'b1, 8'h42);
        bus_write(1'b0, 1'b1, 16'hA501);
        check_reg("R4 stop", 1'b1, 8'h42);
        step(40);
        check_reg("R4 stopped hold", 1'b1, 8'h42);

        // R5 every prescaler tap
        for (int t = 0; t < 8; t++) begin
            int n;
            n = taps[t];
            bus_write(1'b0, 1'b1, 16'hA500);
            bus_write(1'b1, 1'b1, 16'h5A00);
            bus_write(1'b0, 1'b1, {8'hA5, 8'h80 | 8'(t)});
            if (n > 1) begin
                step(n - 1);
                check_reg("R5 before first tick", 1'b1, 8'h00);
            end
            step(1);
            check_reg("R5 first tick", 1'b1, 8'h01);
            step(2 * n);
            check_reg("R5 third tick", 1'b1, 8'h03);
        end
        bus_write(1'b0, 1'b1, 16'hA500);

        // R6 watchdog wrap, power-on request
        bus_write(1'b1, 1'b1, 16'h5AFE);
        bus_write(1'b0, 1'b1, 16'hA5C0);
        step(1);
        check_reg("R6 pre-wrap cnt", 1'b1, 8'hFF);
        check("R6 no early por", {15'd0, por_req}, 16'h0000);
        step(1);
        check_reg("R6 wrapped cnt", 1'b1, 8'h00);
        check("R6 por pulse", {14'd0, por_req, mrst_req}, 16'h0002);
        check_reg("R6 wdog flag", 1'b0, 8'hD0);
        check("R6 no irq", {15'd0, irq}, 16'h0000);
        step(1);
        check("R6 por one cycle", {15'd0, por_req}, 16'h0000);
        bus_write(1'b0, 1'b1, 16'hA510);
        check_reg("R9 flag kept by 1", 1'b0, 8'h10);

        // R11 internal reset keeps the control register
        bus_write(1'b0, 1'b1, 16'hA535);
        check_reg("R11 setup", 1'b0, 8'h35);
        bus_write(1'b1, 1'b1, 16'h5A33);
        core_rst_n = 1'b0;
        step(1);
        core_rst_n = 1'b1;
        check_reg("R11 cnt cleared", 1'b1, 8'h00);
        check_reg("R11 ctrl kept", 1'b0, 8'h35);

        // R9 clear by writing 0
        bus_write(1'b0, 1'b1, 16'hA525);
        check_reg("R9 flag cleared", 1'b0, 8'h25);

        // R7 watchdog wrap, manual request
        bus_write(1'b1, 1'b1, 16'h5AFF);
        bus_write(1'b0, 1'b1, 16'hA5E0);
        check_reg("R7 armed", 1'b0, 8'hE0);
        step(1);
        check("R7 mrst pulse", {14'd0, por_req, mrst_req}, 16'h0001);
        check_reg("R7 wdog flag", 1'b0, 8'hF0);
        step(1);
        check("R7 mrst one cycle", {14'd0, por_req, mrst_req}, 16'h0000);
        bus_write(1'b0, 1'b1, 16'hA510);

        // R8 interval wrap with reset select set
        bus_write(1'b0, 1'b1, 16'hA500);
        bus_write(1'b1, 1'b1, 16'h5AFF);
        bus_write(1'b0, 1'b1, 16'hA5A0);
        step(1);
        check_reg("R8 interval flag", 1'b0, 8'hA8);
        check("R8 irq no reset", {13'd0, por_req, mrst_req, irq}, 16'h0001);
        step(1);
        check("R8 still no reset", {14'd0, por_req, mrst_req}, 16'h0000);
        bus_write(1'b0, 1'b1, 16'hA528);
        check_reg("R8 flag kept", 1'b0, 8'h28);
        check("R8 irq held", {15'd0, irq}, 16'h0001);
        bus_write(1'b0, 1'b1, 16'hA538);
        check_reg("R9 ones change nothing", 1'b0, 8'h28);
        bus_write(1'b0, 1'b1, 16'hA520);
        check_reg("R9 interval cleared", 1'b0, 8'h20);
        check("R8 irq dropped", {15'd0, irq}, 16'h0000);

        // R10 wrap meets clear, watchdog flag
        bus_write(1'b1, 1'b1, 16'h5AFE);
        bus_write(1'b0, 1'b1, 16'hA5C0);
        step(1);
        bus_write(1'b0, 1'b1, 16'hA5C0);
        check_reg("R10 wdog flag wins", 1'b0, 8'hD0);
        check("R10 por pulse", {15'd0, por_req}, 16'h0001);
        bus_write(1'b0, 1'b1, 16'hA500);
        check_reg("R9 clear without wrap", 1'b0, 8'h00);

        // R10 wrap meets clear, interval flag
        bus_write(1'b1, 1'b1, 16'h5AFE);
        bus_write(1'b0, 1'b1, 16'hA580);
        step(1);
        bus_write(1'b0, 1'b1, 16'hA580);
        check_reg("R10 interval flag wins", 1'b0, 8'h88);
        check("R10 irq", {15'd0, irq}, 16'h0001);
        bus_write(1'b0, 1'b1, 16'hA500);
        check_reg("R9 final clear", 1'b0, 8'h00);
        check("R8 irq off", {15'd0, irq}, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule